// File: doc/BRIEF.md
# Read-Capture Calibration Stage Sequencer

This block drives the first two read-capture calibration stages of a memory PHY that has one capture phase-aligner per read-strobe group. After a start request it runs a lock stage. Every aligner is held in calibration mode and a read command is issued on every cycle, so the strobe toggles without a break. When all aligners report lock, the aligners are returned to normal mode and the lock stage is marked done.

The block then runs a preamble-search stage. It steps a candidate read-data offset upward, starting at the configured read latency. For each candidate it issues one burst of four consecutive reads followed by a fixed idle gap. While that step lasts it gathers the preamble-detect flags of every strobe group. The first candidate at which every group of a bank has flagged becomes that bank's shared offset.

Each stage has a timeout with its own sticky error flag. A failed lock stage stops the sequence, and the search stage is never entered.

Top module: `rdcal_seq`

## Requirements
- R1: After reset the block is idle, with all outputs low. A high start_i while idle enters the lock stage. In every cycle of the lock stage, all cal_mode_o bits and rd_cmd_o are high.
- R2: lock_done_o rises in the cycle after a cycle in which every lock_i bit was high during the lock stage. It never rises while only some bits are high. cal_mode_o returns to all zero in the same cycle.
- R3: If the lock stage runs for LOCK_TO (default 64) cycles without full lock, lock_err_o is set. Reads stop, cal_mode_o goes low, and the search stage never starts.
- R4: The search stage is divided into steps of 4+GAP_CYC (default 8) cycles. rd_cmd_o is high for the first 4 cycles of each step and low for the remaining GAP_CYC cycles. cand_ofs_o equals rd_lat_i in the first step, stays constant within a step, and rises by 1 at each new step.
- R5: Group g belongs to bank g/GRP_PER_BANK (default 2 groups per bank, 3 banks). Each bank's offset, at bank_ofs_o[b*OFS_W +: OFS_W], is the first candidate at which every group of the bank raised pre_det_i at least once during that step. Finding it sets bank_found_o[b].
- R6: A recorded offset is never below rd_lat_i. It equals rd_lat_i when all groups of the bank detect at the first step.
- R7: When every bank has been found, srch_done_o is set at the end of that step and reads stop.
- R8: If banks are still missing after MAX_STEPS (default 16) steps, srch_err_o is set and srch_done_o stays low. Banks found earlier keep their offsets.
- R9: Done and error flags hold until reset. A start_i outside the idle state has no effect, so no new reads are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin calibration (accepted while idle) |
| rd_lat_i | input | OFS_W | Read latency, the first candidate offset; sampled when the lock stage ends |
| lock_i | input | NUM_BANKS*GRP_PER_BANK | Lock report per aligner |
| pre_det_i | input | NUM_BANKS*GRP_PER_BANK | Preamble-detect flag per strobe group |
| cal_mode_o | output | NUM_BANKS*GRP_PER_BANK | Calibration-mode select per aligner |
| rd_cmd_o | output | 1 | Read command strobe |
| cand_ofs_o | output | OFS_W | Candidate offset under test |
| lock_done_o | output | 1 | Lock stage complete |
| lock_err_o | output | 1 | Lock stage timed out |
| srch_done_o | output | 1 | Offset search complete |
| srch_err_o | output | 1 | Offset search timed out |
| bank_ofs_o | output | NUM_BANKS*OFS_W | Chosen offset per bank |
| bank_found_o | output | NUM_BANKS | Offset recorded per bank |

## Verification
The hardest cases to reach are at the edges of the search window. One bank's slowest group may detect only on the final permitted step, which must still succeed, or one step later, which must fail while the other banks keep their offsets. The bench models each group as detecting once the candidate reaches a per-group threshold, so a bank's expected offset is the largest threshold among its groups. It places thresholds at rd_lat_i, at rd_lat_i+15 and at rd_lat_i+16. A held partial lock and a lock that never arrives exercise the lock-stage gate and its timeout.

// File: rtl/rdcal_pkg.sv
package rdcal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOCK,
    ST_SRCH,
    ST_DONE,
    ST_FAIL
  } rdcal_st_e;

  localparam int unsigned BURST_LEN = 4;
endpackage

// File: rtl/rdcal_lock_ctl.sv
module rdcal_lock_ctl #(
  parameter int unsigned NG      = 6,
  parameter int unsigned LOCK_TO = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NG-1:0] lock_i,
  output logic          ok_o,
  output logic          to_o
);
  localparam int unsigned TW = (LOCK_TO > 1) ? $clog2(LOCK_TO) : 1;

  logic [TW-1:0] tmr_q;

  assign ok_o = en_i && (&lock_i);
  assign to_o = en_i && !(&lock_i) && (tmr_q == TW'(LOCK_TO - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   tmr_q <= '0;
    else if (!en_i)                tmr_q <= '0;
    else if (tmr_q != TW'(LOCK_TO - 1)) tmr_q <= tmr_q + 1'b1;
  end

  a_r3_timeout_only_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_o |-> !ok_o && en_i);
endmodule

// File: rtl/rdcal_burst_gen.sv
module rdcal_burst_gen
  import rdcal_pkg::*;
#(
  parameter int unsigned GAP_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic rd_o,
  output logic step_end_o
);
  localparam int unsigned STEP_LEN = BURST_LEN + GAP_CYC;
  localparam int unsigned PW       = $clog2(STEP_LEN);

  logic [PW-1:0] ph_q;

  assign rd_o       = en_i && (ph_q < PW'(BURST_LEN));
  assign step_end_o = en_i && (ph_q == PW'(STEP_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ph_q <= '0;
    else if (!en_i)                       ph_q <= '0;
    else if (ph_q == PW'(STEP_LEN - 1))   ph_q <= '0;
    else                                  ph_q <= ph_q + 1'b1;
  end

  a_r4_gap_at_step_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_end_o |-> !rd_o);
  a_r4_burst_starts_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rd_o) && $past(en_i)) |-> $past(step_end_o));
endmodule

// File: rtl/rdcal_bank_pick.sv
module rdcal_bank_pick #(
  parameter int unsigned NUM_BANKS    = 3,
  parameter int unsigned GRP_PER_BANK = 2,
  parameter int unsigned OFS_W        = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       step_end_i,
  input  logic [NUM_BANKS*GRP_PER_BANK-1:0] pre_det_i,
  input  logic [OFS_W-1:0]           cand_i,
  input  logic [OFS_W-1:0]           rl_i,
  output logic [NUM_BANKS*OFS_W-1:0] bank_ofs_o,
  output logic [NUM_BANKS-1:0]       bank_found_o,
  output logic                       all_found_o
);
  localparam int unsigned NG = NUM_BANKS * GRP_PER_BANK;

  logic [NG-1:0]        seen_q, seen_now;
  logic [NUM_BANKS-1:0] found_q, hit;
  logic [OFS_W-1:0]     ofs_q [NUM_BANKS];

  assign seen_now = seen_q | pre_det_i;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign hit[b] = en_i && step_end_i && !found_q[b] &&
                    (&seen_now[b*GRP_PER_BANK +: GRP_PER_BANK]);
    assign bank_ofs_o[b*OFS_W +: OFS_W] = ofs_q[b];

    a_r6_ofs_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
      found_q[b] |-> ofs_q[b] >= rl_i);
    a_r5_ofs_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(found_q[b]) |-> $stable(ofs_q[b]) && found_q[b]);
  end

  assign bank_found_o = found_q;
  assign all_found_o  = &(found_q | hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      seen_q <= '0;
    else if (!en_i || step_end_i)     seen_q <= '0;
    else                              seen_q <= seen_now;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      found_q <= '0;
      for (int b = 0; b < NUM_BANKS; b++) ofs_q[b] <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (hit[b]) begin
          found_q[b] <= 1'b1;
          ofs_q[b]   <= cand_i;
        end
      end
    end
  end
endmodule

// File: rtl/rdcal_seq.sv
module rdcal_seq
  import rdcal_pkg::*;
#(
  parameter int unsigned NUM_BANKS    = 3,
  parameter int unsigned GRP_PER_BANK = 2,
  parameter int unsigned OFS_W        = 6,
  parameter int unsigned GAP_CYC      = 4,
  parameter int unsigned LOCK_TO      = 64,
  parameter int unsigned MAX_STEPS    = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              start_i,
  input  logic [OFS_W-1:0]                  rd_lat_i,
  input  logic [NUM_BANKS*GRP_PER_BANK-1:0] lock_i,
  input  logic [NUM_BANKS*GRP_PER_BANK-1:0] pre_det_i,
  output logic [NUM_BANKS*GRP_PER_BANK-1:0] cal_mode_o,
  output logic                              rd_cmd_o,
  output logic [OFS_W-1:0]                  cand_ofs_o,
  output logic                              lock_done_o,
  output logic                              lock_err_o,
  output logic                              srch_done_o,
  output logic                              srch_err_o,
  output logic [NUM_BANKS*OFS_W-1:0]        bank_ofs_o,
  output logic [NUM_BANKS-1:0]              bank_found_o
);
  localparam int unsigned NG = NUM_BANKS * GRP_PER_BANK;
  localparam int unsigned SW = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1;

  rdcal_st_e       st_q;
  logic            lock_ok, lock_to, burst_rd, step_end, all_found;
  logic            lock_done_q, lock_err_q, srch_done_q, srch_err_q;
  logic [OFS_W-1:0] cand_q, rl_q;
  logic [SW-1:0]   step_q;

  rdcal_lock_ctl #(.NG(NG), .LOCK_TO(LOCK_TO)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (st_q == ST_LOCK),
    .lock_i (lock_i),
    .ok_o   (lock_ok),
    .to_o   (lock_to)
  );

  rdcal_burst_gen #(.GAP_CYC(GAP_CYC)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (st_q == ST_SRCH),
    .rd_o       (burst_rd),
    .step_end_o (step_end)
  );

  rdcal_bank_pick #(
    .NUM_BANKS(NUM_BANKS), .GRP_PER_BANK(GRP_PER_BANK), .OFS_W(OFS_W)
  ) u_pick (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (st_q == ST_SRCH),
    .step_end_i   (step_end),
    .pre_det_i    (pre_det_i),
    .cand_i       (cand_q),
    .rl_i         (rl_q),
    .bank_ofs_o   (bank_ofs_o),
    .bank_found_o (bank_found_o),
    .all_found_o  (all_found)
  );

  assign cal_mode_o  = {NG{st_q == ST_LOCK}};
  assign rd_cmd_o    = (st_q == ST_LOCK) || burst_rd;
  assign cand_ofs_o  = cand_q;
  assign lock_done_o = lock_done_q;
  assign lock_err_o  = lock_err_q;
  assign srch_done_o = srch_done_q;
  assign srch_err_o  = srch_err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      lock_done_q <= 1'b0;
      lock_err_q  <= 1'b0;
      srch_done_q <= 1'b0;
      srch_err_q  <= 1'b0;
      cand_q      <= '0;
      rl_q        <= '0;
      step_q      <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) st_q <= ST_LOCK;
        ST_LOCK: begin
          if (lock_ok) begin
            lock_done_q <= 1'b1;
            st_q        <= ST_SRCH;
            cand_q      <= rd_lat_i;
            rl_q        <= rd_lat_i;
            step_q      <= '0;
          end else if (lock_to) begin
            lock_err_q <= 1'b1;
            st_q       <= ST_FAIL;
          end
        end
        ST_SRCH: begin
          if (step_end) begin
            if (all_found) begin
              srch_done_q <= 1'b1;
              st_q        <= ST_DONE;
            end else if (step_q == SW'(MAX_STEPS - 1)) begin
              srch_err_q <= 1'b1;
              st_q       <= ST_FAIL;
            end else begin
              cand_q <= cand_q + 1'b1;
              step_q <= step_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  a_r1_start_enters_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cal_mode_o[0]) |-> $past(start_i));
  a_r1_lock_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_mode_o[0] |-> rd_cmd_o && !lock_done_o);
  a_r2_lock_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_done_o) |-> $past(&lock_i) && (cal_mode_o == '0));
  a_r3_fail_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_err_o |-> !rd_cmd_o && !lock_done_o && !srch_done_o);
  a_r4_cand_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SRCH && $past(st_q) == ST_SRCH && !$past(step_end)) |-> $stable(cand_q));
  a_r7_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srch_done_o |-> !rd_cmd_o && !srch_err_o && (&bank_found_o));
  a_r8_err_incomplete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(srch_err_o) |-> !(&bank_found_o));
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lock_err_o) |-> lock_err_o) and ($past(srch_err_o) |-> srch_err_o) and
    ($past(lock_done_o) |-> lock_done_o) and ($past(srch_done_o) |-> srch_done_o));
endmodule

// File: tb/rdcal_seq_tb.sv
module rdcal_seq_tb;
  localparam int NB = 3, GPB = 2, NG = 6, OW = 6;

  logic          clk = 0, rst_n = 0, start = 0;
  logic [OW-1:0] rd_lat = '0;
  logic [NG-1:0] lock = '0, pre_det;
  logic [NG-1:0] cal_mode;
  logic          rd_cmd, lock_done, lock_err, srch_done, srch_err;
  logic [OW-1:0] cand;
  logic [NB*OW-1:0] bank_ofs;
  logic [NB-1:0] bank_found;
  logic [OW-1:0] true_ofs [NG];

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  always_comb
    for (int g = 0; g < NG; g++) pre_det[g] = (cand >= true_ofs[g]);

  rdcal_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_lat_i(rd_lat),
    .lock_i(lock), .pre_det_i(pre_det), .cal_mode_o(cal_mode), .rd_cmd_o(rd_cmd),
    .cand_ofs_o(cand), .lock_done_o(lock_done), .lock_err_o(lock_err),
    .srch_done_o(srch_done), .srch_err_o(srch_err), .bank_ofs_o(bank_ofs),
    .bank_found_o(bank_found)
  );

  localparam int V_RL [4] = '{5, 7, 3, 3};
  localparam int V_OFS [4][6] = '{
    '{9, 10, 9, 9, 11, 10},
    '{7, 7, 7, 7, 7, 7},
    '{8, 3, 12, 4, 18, 5},
    '{4, 4, 4, 4, 19, 4}
  };
  localparam int V_EXP [4][3] = '{'{10, 9, 11}, '{7, 7, 7}, '{8, 12, 18}, '{4, 4, 0}};
  localparam int V_ERR [4]   = '{0, 0, 0, 1};
  localparam int V_FND [4]   = '{7, 7, 7, 3};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; start = 0; lock = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_search();
    for (int i = 0; i < 300; i++) begin
      if (srch_done || srch_err) break;
      @(negedge clk);
    end
  endtask

  initial begin
    for (int g = 0; g < NG; g++) true_ofs[g] = 6'd20;
    do_reset();
    check(rd_cmd == 0 && cal_mode == 0 && lock_done == 0 && lock_err == 0 &&
          srch_done == 0 && srch_err == 0 && bank_found == 0, "R1 reset idle",
          int'(rd_cmd), 0);

    // directed: partial lock, then full lock, then burst pattern
    rd_lat = 6'd5;
    pulse_start();
    check(cal_mode == '1 && rd_cmd == 1, "R1 lock stage cal mode", int'(cal_mode), 63);
    lock = 6'b011111;
    begin
      int bad = 0;
      for (int i = 0; i < 10; i++) begin
        if (!rd_cmd || lock_done || cal_mode != '1) bad++;
        @(negedge clk);
      end
      check(bad == 0, "R2 partial lock holds stage", bad, 0);
    end
    lock = '1;
    @(negedge clk);
    check(lock_done == 1 && cal_mode == 0, "R2 lock done, normal mode", int'(lock_done), 1);
    begin
      int bad_rd = 0, bad_c = 0;
      for (int i = 0; i < 16; i++) begin
        if (rd_cmd != ((i % 8) < 4)) bad_rd++;
        if (cand != OW'(5 + i / 8)) bad_c++;
        @(negedge clk);
      end
      check(bad_rd == 0, "R4 four reads then gap", bad_rd, 0);
      check(bad_c == 0, "R4 candidate start and step", bad_c, 0);
    end
    wait_search();
    check(srch_done == 1 && srch_err == 0, "R7 search done", int'(srch_done), 1);
    check(bank_ofs == {3{6'd20}}, "R5 offsets at 20", int'(bank_ofs[5:0]), 20);
    @(negedge clk);
    check(rd_cmd == 0, "R7 reads stop", int'(rd_cmd), 0);
    pulse_start();
    repeat (3) @(negedge clk);
    check(rd_cmd == 0 && cal_mode == 0 && srch_done == 1, "R9 start ignored after done",
          int'(rd_cmd), 0);

    // vector table
    for (int v = 0; v < 4; v++) begin
      do_reset();
      rd_lat = OW'(V_RL[v]);
      for (int g = 0; g < NG; g++) true_ofs[g] = OW'(V_OFS[v][g]);
      lock = '1;
      pulse_start();
      wait_search();
      check(int'(srch_err) == V_ERR[v] && int'(srch_done) == 1 - V_ERR[v],
            $sformatf("R8 vec%0d error flag", v), int'(srch_err), V_ERR[v]);
      check(int'(bank_found) == V_FND[v], $sformatf("R5 vec%0d found mask", v),
            int'(bank_found), V_FND[v]);
      for (int b = 0; b < NB; b++)
        if (V_FND[v][b])
          check(int'(bank_ofs[b*OW +: OW]) == V_EXP[v][b],
                $sformatf("R5 vec%0d bank%0d offset", v, b),
                int'(bank_ofs[b*OW +: OW]), V_EXP[v][b]);
      if (v == 1)
        check(int'(bank_ofs[5:0]) == V_RL[v], "R6 offset equals latency",
              int'(bank_ofs[5:0]), V_RL[v]);
      repeat (4) @(negedge clk);
      check(srch_err == V_ERR[v][0] && rd_cmd == 0, $sformatf("R9 vec%0d sticky", v),
            int'(srch_err), V_ERR[v]);
    end

    // directed: lock timeout
    do_reset();
    lock = 6'b111110;
    pulse_start();
    repeat (70) @(negedge clk);
    check(lock_err == 1 && lock_done == 0, "R3 lock timeout", int'(lock_err), 1);
    check(rd_cmd == 0 && cal_mode == 0, "R3 reads stop on timeout", int'(rd_cmd), 0);
    lock = '1;
    pulse_start();
    begin
      int rds = 0;
      for (int i = 0; i < 20; i++) begin
        if (rd_cmd) rds++;
        @(negedge clk);
      end
      check(rds == 0 && srch_done == 0 && srch_err == 0, "R3 no search after fail", rds, 0);
    end
    check(lock_err == 1, "R9 lock error sticky", int'(lock_err), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end
endmodule